// File: doc/BRIEF.md
# I2C Line Override and Monitor

This block sits between an I2C master engine and the open-drain pad cells of SCL and SDA. It lets software see the live state of both bus lines and, when a slave has wedged the bus, take the pins away from the engine and drive the clock by hand. A two-bit control register selects who owns the pins. With the run bit set, the engine's pull-low enables pass straight to the pads. With the run bit clear, the block owns the pins. In that mode SDA is always released, so a stuck slave can finish shifting out its byte. SCL is pulled low or released according to a release bit, so software can toggle that bit to make clock pulses. Writing both control bits as one hands the pins back to the engine.

A four-bit monitor word is always readable. Its even bits carry the SCL and SDA pin levels after a synchronizer. Its odd bits show the level that this block is currently driving onto each line. All pad-side signals are pull-low enables: 1 means the pad pulls the line low and 0 means it releases the line. No data stream passes through the block, so there is no valid/ready handshake. Every port is a plain level signal, and a register write is a single-cycle strobe that is always accepted.

Top module: `i2c_line_override`

## Requirements
- R1: After reset the control register holds run=1 and release=1. The sync stages read as 1, so with the engine enables low and both pins high the monitor reads 4'hF.
- R2: While control bit 1 (run) is 1, scl_oe equals eng_scl_oe and sda_oe equals eng_sda_oe in the same cycle.
- R3: While run is 0 and control bit 0 (release) is 0, scl_oe is 1 (SCL pulled low) whatever the engine drives.
- R4: While run is 0 and release is 1, scl_oe is 0 (SCL released) whatever the engine drives.
- R5: While run is 0, sda_oe is 0 (SDA released) whatever the engine drives.
- R6: Monitor bit 0 shows scl_in and monitor bit 2 shows sda_in, each delayed by exactly SYNC_STAGES (default 2) rising clock edges.
- R7: Monitor bit 1 equals the inverse of scl_oe and monitor bit 3 equals the inverse of sda_oe, in the same cycle. A 1 means the line is released.
- R8: A cycle with cfg_we high loads cfg_wdata (bit 1 run, bit 0 release) into the control register at that clock edge. With cfg_we low the register holds its value. Writing 2'b11 from override mode returns the pins to the engine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | Control write data: bit 1 run, bit 0 SCL release |
| eng_scl_oe | input | 1 | Engine SCL pull-low enable |
| eng_sda_oe | input | 1 | Engine SDA pull-low enable |
| scl_in | input | 1 | SCL pad input level |
| sda_in | input | 1 | SDA pad input level |
| scl_oe | output | 1 | SCL pad pull-low enable |
| sda_oe | output | 1 | SDA pad pull-low enable |
| mon_rdata | output | 4 | Monitor word: {SDA drive, SDA sync, SCL drive, SCL sync} |

## Verification
The embedded assertions check the following on every clock:
- the pin multiplexing rules for both modes;
- the stage-by-stage advance of the synchronizer chain;
- that the control register only changes on a write strobe and then takes the written value;
- that the monitor drive bits track the pad enables.

Only the bench's scenarios can show the end-to-end behaviour. These cover the reset value seen at the ports, and the exact two-edge latency from a pin change to the monitor word under random pin activity. They also cover whole recovery sequences, in which software drops into override, toggles the release bit to pulse SCL, and then hands the bus back with a single write.

// File: rtl/i2c_ovr_pkg.sv
package i2c_ovr_pkg;
  localparam int CTL_W  = 2;
  localparam int MON_W  = 4;
  // control bit positions
  localparam int CTL_REL = 0;
  localparam int CTL_RUN = 1;
  // monitor bit positions
  localparam int MON_SCL_SYNC  = 0;
  localparam int MON_SCL_DRIVE = 1;
  localparam int MON_SDA_SYNC  = 2;
  localparam int MON_SDA_DRIVE = 3;

  typedef struct packed {
    logic run;
    logic rel;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{run: 1'b1, rel: 1'b1};
endpackage

// File: rtl/i2c_ovr_sync.sv
module i2c_ovr_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];
  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
        assert_stage_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
          live_q |-> stg[0] == $past(d));
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
        assert_stage_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
          live_q |-> stg[i] == $past(stg[i-1]));
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_ovr_ctl.sv
module i2c_ovr_ctl
  import i2c_ovr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl <= CTL_RESET;
    else if (we) ctl <= ctl_t'(wdata);
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl));
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ctl == ctl_t'($past(wdata)));
endmodule

// File: rtl/i2c_ovr_mux.sv
module i2c_ovr_mux
  import i2c_ovr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl,
  input  logic eng_scl_oe,
  input  logic eng_sda_oe,
  output logic scl_oe,
  output logic sda_oe
);
  always_comb begin
    if (ctl.run) begin
      scl_oe = eng_scl_oe;
      sda_oe = eng_sda_oe;
    end else begin
      scl_oe = ~ctl.rel;
      sda_oe = 1'b0;
    end
  end

  assert_engine_owns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.run |-> (scl_oe == eng_scl_oe && sda_oe == eng_sda_oe));
  assert_scl_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !ctl.rel) |-> scl_oe);
  assert_scl_freed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && ctl.rel) |-> !scl_oe);
  assert_sda_freed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.run |-> !sda_oe);
endmodule

// File: rtl/i2c_line_override.sv
module i2c_line_override
  import i2c_ovr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CTL_W-1:0] cfg_wdata,
  input  logic             eng_scl_oe,
  input  logic             eng_sda_oe,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [MON_W-1:0] mon_rdata
);
  localparam int NLINES = 2;

  ctl_t ctl;
  logic [NLINES-1:0] pins_sync;

  i2c_ovr_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .ctl   (ctl)
  );

  i2c_ovr_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sda_in, scl_in}),
    .q     (pins_sync)
  );

  i2c_ovr_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .eng_scl_oe (eng_scl_oe),
    .eng_sda_oe (eng_sda_oe),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );

  always_comb begin
    mon_rdata                = '0;
    mon_rdata[MON_SCL_SYNC]  = pins_sync[0];
    mon_rdata[MON_SDA_SYNC]  = pins_sync[1];
    mon_rdata[MON_SCL_DRIVE] = ~scl_oe;
    mon_rdata[MON_SDA_DRIVE] = ~sda_oe;
  end

  assert_drive_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_rdata[MON_SCL_DRIVE] != scl_oe) && (mon_rdata[MON_SDA_DRIVE] != sda_oe));
endmodule

// File: tb/i2c_line_override_tb.sv
module i2c_line_override_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_CYCLES   = 800;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_wdata;
  logic eng_scl_oe, eng_sda_oe, scl_in, sda_in;
  logic scl_oe, sda_oe;
  logic [3:0] mon_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_line_override u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .mon_rdata(mon_rdata)
  );

  // expected {scl_oe, sda_oe} from control bits and engine enables
  function automatic logic [1:0] exp_oe(logic [1:0] c, logic e_scl, logic e_sda);
    if (c[1]) return {e_scl, e_sda};
    return {~c[0], 1'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [1:0] ctl_m;
  logic       pend_we;
  logic [1:0] pend_data;
  logic [1:0] h1, h2;  // {sda,scl} driven one and two cycles ago

  task automatic drive(logic we, logic [1:0] wd, logic es, logic ed, logic sc, logic sd);
    cfg_we = we; cfg_wdata = wd;
    eng_scl_oe = es; eng_sda_oe = ed;
    scl_in = sc; sda_in = sd;
    pend_we = we; pend_data = wd;
    h2 = h1; h1 = {sd, sc};
  endtask

  task automatic step_check();
    logic [1:0] e;
    string rq;
    if (pend_we) ctl_m = pend_data;
    e = exp_oe(ctl_m, eng_scl_oe, eng_sda_oe);
    if (ctl_m[1])      rq = "R2";
    else if (!ctl_m[0]) rq = "R3";
    else               rq = "R4";
    if (pend_we && ctl_m == 2'b11) rq = {rq, "/R8"};
    check(rq, {7'd0, scl_oe}, {7'd0, e[1]});
    check(ctl_m[1] ? "R2" : "R5", {7'd0, sda_oe}, {7'd0, e[0]});
    check("R6", {6'd0, mon_rdata[2], mon_rdata[0]}, {6'd0, h2});
    check("R7", {6'd0, mon_rdata[3], mon_rdata[1]}, {6'd0, ~sda_oe, ~scl_oe});
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    ctl_m = 2'b11; pend_we = 1'b0; pend_data = 2'b00;
    h1 = 2'b11; h2 = 2'b11;
    cfg_we = 0; cfg_wdata = 0; eng_scl_oe = 0; eng_sda_oe = 0; scl_in = 1; sda_in = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {4'd0, mon_rdata}, 8'h0F);
    check("R1", {6'd0, scl_oe, sda_oe}, 8'h00);
    rst_n = 1'b1;
    h1 = 2'b11; h2 = 2'b11;
    // directed recovery sequence: override with SCL low, pulse, hand back
    drive(1, 2'b00, 0, 1, 1, 0);
    @(negedge clk); step_check();
    drive(0, 2'b00, 1, 1, 0, 0);              // R3/R5: engine ignored
    @(negedge clk); step_check();
    drive(1, 2'b01, 1, 1, 1, 0);
    @(negedge clk); step_check();
    drive(0, 2'b01, 1, 1, 1, 1);              // R4: engine ignored
    @(negedge clk); step_check();
    drive(1, 2'b00, 0, 0, 0, 1);
    @(negedge clk); step_check();
    drive(1, 2'b11, 1, 0, 1, 1);              // R8: return to engine
    @(negedge clk); step_check();
    drive(0, 2'b00, 0, 1, 1, 1);              // R8: no write, hold
    @(negedge clk); step_check();
    // random mix
    for (int k = 0; k < N_CYCLES; k++) begin
      logic w;
      w = ($urandom_range(0, 5) == 0);
      drive(w, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      @(negedge clk); step_check();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule